// File: doc/BRIEF.md
# M1 Strobe Controller with Mode Register

This block drives the active-low M1 machine-cycle strobe of an 8-bit processor bus and holds the small operation-mode register that decides when the strobe fires. Each bus cycle the core presents a cycle-type code and, for opcode fetches, the opcode byte being fetched. The block registers the resulting strobe level on the clock edge where the cycle description is valid.

Two strobe policies exist. In the conventional policy, every opcode fetch, every maskable interrupt acknowledge and the first machine cycle of a non-maskable interrupt acknowledge drive M1 low. Both fetches of the two-byte return-from-interrupt instruction are included. In the daisy-chain-safe policy, M1 stays high except on maskable interrupt acknowledge and on the second byte of the return-from-interrupt instruction. This keeps peripherals on an interrupt priority chain from seeing spurious M1 pulses. The return-from-interrupt instruction is recognised as a fetch of 0xED followed directly by a fetch of 0x4D. Software selects the policy through the enable bit of the mode register.

Top module: `m1_strobe_ctl`

## Requirements
- R1: Synchronous active-high reset sets m1_n to 1, clears the return-from-interrupt tracker and the interrupt-acknowledge history, and loads the mode register so that rd_data reads 8'hFF.
- R2: A write (wr_en=1) loads the strobe-enable bit from wr_data[7] and the I/O compatibility bit from wr_data[5]. From the next cycle on, rd_data reads {enable, 1, iocompat, 5'b11111}. Bit 6 is write-only and bits 4..0 are reserved, and all of them read as 1.
- R3: With the enable bit at 1, a valid opcode fetch cycle (cyc_type=2'b01) drives m1_n low after the clock edge, whatever the opcode byte.
- R4: With the enable bit at 1, a valid non-maskable acknowledge cycle (cyc_type=2'b11) drives m1_n low only when the previous valid cycle was not a non-maskable acknowledge. Later cycles of the same acknowledge drive it high.
- R5: A valid maskable interrupt acknowledge cycle (cyc_type=2'b10) drives m1_n low under both settings of the enable bit.
- R6: With the enable bit at 0, a valid fetch drives m1_n low only if its byte is 0x4D and the previous valid cycle was a fetch of 0xED. All other fetches, and all non-maskable acknowledge cycles, drive m1_n high.
- R7: A valid cycle that is not a fetch, or a fetch of any byte other than 0xED, clears the tracker, so a following 0x4D fetch is not a refetch.
- R8: While cyc_valid is 0, m1_n holds its value, and the tracker and the acknowledge history are unchanged.
- R9: A valid cycle of type "other" (cyc_type=2'b00) drives m1_n high.
- R10: When a write and a valid cycle fall on the same edge, that cycle's strobe uses the enable bit from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write data |
| rd_data | output | 8 | Mode register read value |
| cyc_valid | input | 1 | Cycle description valid this clock |
| cyc_type | input | 2 | 00 other, 01 opcode fetch, 10 maskable ack, 11 non-maskable ack |
| op_byte | input | 8 | Opcode byte of the current fetch |
| m1_n | output | 1 | Registered M1 strobe, active low |

## Verification
On every cycle the assertions check the strobe's holding behaviour, the strobe for "other" and maskable-acknowledge cycles, the conventional fetch strobe, the daisy-chain-safe suppression of ordinary fetches, the register readback format and the reset state. The behaviours that depend on history are shown only by the bench's scenarios: recognising 0xED then 0x4D, breaking that pair with an intervening cycle, the first-cycle-only rule for non-maskable acknowledges, and the write that shares an edge with a cycle. The random mix of cycles, bytes and writes is compared against a reference model in the bench.

// File: rtl/m1_strobe_ctl.sv
module m1_strobe_ctl #(
  parameter int          DW        = 8,
  parameter int          TW        = 2,
  parameter logic [DW-1:0] PREFIX_OP = 8'hED,
  parameter logic [DW-1:0] RETURN_OP = 8'h4D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cyc_valid,
  input  logic [TW-1:0] cyc_type,
  input  logic [DW-1:0] op_byte,
  output logic          m1_n
);
  localparam logic [TW-1:0] T_OTHER = 2'b00;
  localparam logic [TW-1:0] T_FETCH = 2'b01;
  localparam logic [TW-1:0] T_INTA  = 2'b10;
  localparam logic [TW-1:0] T_NMIA  = 2'b11;
  localparam int EN_BIT  = DW - 1;
  localparam int IOC_BIT = DW - 3;

  logic en_q, ioc_q;
  logic prefix_seen, nmi_prev;
  logic is_fetch, is_inta, is_nmia, refetch, m1_act;

  assign is_fetch = cyc_type == T_FETCH;
  assign is_inta  = cyc_type == T_INTA;
  assign is_nmia  = cyc_type == T_NMIA;
  assign refetch  = is_fetch && prefix_seen && (op_byte == RETURN_OP);

  always_comb begin
    m1_act = 1'b0;
    if (is_inta)
      m1_act = 1'b1;
    else if (en_q)
      m1_act = is_fetch || (is_nmia && !nmi_prev);
    else
      m1_act = refetch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      ioc_q <= 1'b1;
    end else if (wr_en) begin
      en_q  <= wr_data[EN_BIT];
      ioc_q <= wr_data[IOC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prefix_seen <= 1'b0;
      nmi_prev    <= 1'b0;
      m1_n        <= 1'b1;
    end else if (cyc_valid) begin
      prefix_seen <= is_fetch && (op_byte == PREFIX_OP);
      nmi_prev    <= is_nmia;
      m1_n        <= !m1_act;
    end
  end

  always_comb begin
    rd_data          = '1;
    rd_data[EN_BIT]  = en_q;
    rd_data[IOC_BIT] = ioc_q;
  end

  wire unused_t = (cyc_type == T_OTHER);
endmodule

// File: rtl/m1_strobe_ctl_chk.sv
module m1_strobe_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       cyc_valid,
  input logic [1:0] cyc_type,
  input logic [7:0] op_byte,
  input logic       m1_n
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (m1_n && rd_data == 8'hFF));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == {$past(wr_data[7]), 1'b1, $past(wr_data[5]), 5'b11111});

  p_fetch_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type == 2'b01 && rd_data[7]) |=> !m1_n);

  p_inta_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type == 2'b10) |=> !m1_n);

  p_safe_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type == 2'b01 && !rd_data[7] && op_byte != 8'h4D) |=> m1_n);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |=> $stable(m1_n));

  p_other_high_r9: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type == 2'b00) |=> m1_n);
endmodule

bind m1_strobe_ctl m1_strobe_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .cyc_valid(cyc_valid), .cyc_type(cyc_type), .op_byte(op_byte), .m1_n(m1_n)
);

// File: tb/m1_strobe_ctl_test.sv
`timescale 1ns/1ps
module m1_strobe_ctl_test;
  logic       clk = 1'b0;
  logic       rst, wr_en, cyc_valid;
  logic [7:0] wr_data, op_byte, rd_data;
  logic [1:0] cyc_type;
  logic       m1_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit md_en, md_ioc, md_seen, md_nmi, md_m1n;

  always #5 clk = ~clk;

  m1_strobe_ctl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type), .op_byte(op_byte), .m1_n(m1_n)
  );

  function automatic bit exp_active(bit en, bit seen, bit nmi, logic [1:0] t, logic [7:0] b);
    if (t == 2'b10) return 1'b1;
    if (en) return (t == 2'b01) || (t == 2'b11 && !nmi);
    return (t == 2'b01) && seen && (b == 8'h4D);
  endfunction

  function automatic logic [7:0] exp_rd(bit en, bit ioc);
    return {en, 1'b1, ioc, 5'b11111};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit w, logic [7:0] wd, bit v, logic [1:0] t, logic [7:0] b, string req);
    wr_en = w; wr_data = wd; cyc_valid = v; cyc_type = t; op_byte = b;
    @(posedge clk);
    if (v) begin
      md_m1n  = !exp_active(md_en, md_seen, md_nmi, t, b);
      md_seen = (t == 2'b01) && (b == 8'hED);
      md_nmi  = (t == 2'b11);
    end
    if (w) begin md_en = wd[7]; md_ioc = wd[5]; end
    @(negedge clk);
    check(req, {7'd0, m1_n}, {7'd0, md_m1n});
    check("R2", rd_data, exp_rd(md_en, md_ioc));
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; wr_data = 0; cyc_valid = 0; cyc_type = 0; op_byte = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    md_en = 1; md_ioc = 1; md_seen = 0; md_nmi = 0; md_m1n = 1;
    check("R1", {7'd0, m1_n}, 8'd1);
    check("R1", rd_data, 8'hFF);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0180));
    do_reset();
    // R3 conventional fetch, R9 other
    step(0, 0, 1, 2'b01, 8'h00, "R3");
    step(0, 0, 1, 2'b00, 8'h00, "R9");
    // R4 non-maskable: first only
    step(0, 0, 1, 2'b11, 8'h00, "R4");
    step(0, 0, 1, 2'b11, 8'h00, "R4");
    step(0, 0, 1, 2'b11, 8'h00, "R4");
    step(0, 0, 1, 2'b00, 8'h00, "R9");
    step(0, 0, 1, 2'b11, 8'h00, "R4");
    // R2 write, safe mode; R10 same-edge write uses old enable
    step(1, 8'h5F, 1, 2'b01, 8'h11, "R10");
    step(0, 0, 1, 2'b01, 8'h11, "R6");
    step(0, 0, 1, 2'b10, 8'h00, "R5");
    step(0, 0, 1, 2'b11, 8'h00, "R6");
    // R6 refetch
    step(0, 0, 1, 2'b01, 8'hED, "R6");
    step(0, 0, 1, 2'b01, 8'h4D, "R6");
    // R7 intervening byte / cycle
    step(0, 0, 1, 2'b01, 8'hED, "R7");
    step(0, 0, 1, 2'b01, 8'h22, "R7");
    step(0, 0, 1, 2'b01, 8'h4D, "R7");
    step(0, 0, 1, 2'b01, 8'hED, "R7");
    step(0, 0, 1, 2'b10, 8'h00, "R7");
    step(0, 0, 1, 2'b01, 8'h4D, "R7");
    // R8 idle cycles ignored
    step(0, 0, 1, 2'b01, 8'hED, "R8");
    step(0, 0, 0, 2'b00, 8'h00, "R8");
    step(0, 0, 0, 2'b11, 8'h77, "R8");
    step(0, 0, 1, 2'b01, 8'h4D, "R8");
    step(0, 0, 0, 2'b00, 8'h00, "R8");
    step(1, 8'hA0, 0, 2'b00, 8'h00, "R2");
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b;
      int r = $urandom_range(0, 3);
      b = (r == 0) ? 8'hED : (r == 1) ? 8'h4D : 8'($urandom);
      step(($urandom_range(0, 15) == 0), 8'($urandom), ($urandom_range(0, 4) != 0),
           2'($urandom), b, "R6");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule